// File: doc/BRIEF.md
# Fractional Serial Bit Timer with Receiver and Transmitter

This block times the bits of a half-duplex asynchronous serial link. It receives and sends frames made of a low start bit, eight data bits with the least significant bit first, and a high stop bit. One reload register sets the rate. It holds the number of system clocks that eight bit periods take, so a bit period can be a fraction of a clock, for example 37.5 clocks.

Each direction has its own phase accumulator. The accumulator adds 8 every clock. When the sum reaches the threshold, it subtracts the threshold and raises a tick.

The receiver detects the falling edge of the start bit. It confirms the line at the half-bit point and then samples each bit at its centre. It reports each byte with a one-cycle valid pulse and a framing-error flag. After it samples the middle of the stop bit, it starts looking for the next start edge straight away.

The transmitter shifts out a complete frame when it is started. It holds the line high when idle.

Software writes a reload value over a single-cycle register port. The value takes effect at the next frame boundary. Values below 32 are raised to 32. When the debug-enable input is high, only the low 12 bits of the value are used.

Top module: `fsl_serial_link`

## Requirements
- R1: After reset, `txOut` is high, `txBusy` is low and `rxValid` is low.
- R2: The effective reload value R is the number of clocks in eight bit periods. Bit k of a frame (start bit = 0) begins floor(k*R/8) clocks after the start edge. Non-integer bit periods such as R=300 are received correctly.
- R3: A received byte appears on `rxData` with bit 0 taken from the first data bit after the start bit. `rxValid` is high for exactly one cycle per frame.
- R4: `rxFrameErr` is 1 when the stop bit sampled at its centre is low, and 0 when it is high. It is valid in the same cycle as `rxValid`.
- R5: A low pulse that has ended before the half-bit point of a start bit produces no `rxValid`.
- R6: The receiver accepts a new start edge as soon as it has sampled the centre of the stop bit. A frame whose stop bit lasts only 0.72 of a bit period, followed directly by another frame, yields both bytes.
- R7: A pulse on `txStart` sends 0 (the start bit), then `txData` with the least significant bit first, then 1 (the stop bit). `txBusy` is high for exactly ceil(10*R/8) cycles, and `txOut` is high whenever `txBusy` is low.
- R8: When `dbgEn` is high, the effective reload value is `regWrData[11:0]` of the last write, and bits 15:12 are ignored.
- R9: An effective reload value below 32 is replaced by 32.
- R10: A reload write made while a frame is in progress in either direction does not change the timing of that frame. It applies from the next frame.
- R11: A `txStart` pulse while `txBusy` is high is ignored. The frame in progress neither changes nor gets longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dbgEn | input | 1 | Limits the reload value to its low 12 bits |
| regWrEn | input | 1 | Single-cycle write strobe for the reload register |
| regWrData | input | 16 | Reload value: clocks per eight bit periods |
| rxIn | input | 1 | Serial receive line (asynchronous) |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse when a byte has been received |
| rxFrameErr | output | 1 | Stop bit was sampled low |
| txStart | input | 1 | Starts a transmit frame when the transmitter is idle |
| txData | input | 8 | Byte to send, captured when a frame starts |
| txBusy | output | 1 | A transmit frame is in progress |
| txOut | output | 1 | Serial transmit line |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle width of `rxValid`;
- the high idle level of the transmit line;
- the floor of 32 on the active reload value;
- the 12-bit limit on the active reload value under debug enable;
- the freeze of the active reload value during a transmit frame.

Other behaviour can only be shown by the bench's scenarios:
- correct centre sampling at fractional bit periods;
- rejection of a short start glitch;
- the early restart of the start-edge search in the stop bit;
- exact frame lengths before and after a deferred reload write.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef struct packed {
    logic rxClr;     // hold receive accumulator at zero
    logic rxHalf;    // receive accumulator uses half-bit threshold
    logic rxShift;   // capture one data bit
    logic rxDone;    // stop bit sampled: publish byte
    logic txClr;     // hold transmit accumulator at zero
    logic txLoad;    // load frame into transmit shifter
    logic txShift;   // advance transmit shifter by one bit
    logic reloadOk;  // frame boundary: active reload may update
  } fslCtrl_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

  typedef enum logic {
    TX_IDLE,
    TX_RUN
  } txState_e;

endpackage

// File: rtl/fsl_phase_acc.sv
module fsl_phase_acc #(
  parameter int RLD_W = 16,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             halfMode,
  input  logic [RLD_W-1:0] reload,
  output logic             tick
);

  localparam int ACC_W = RLD_W + 1;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] thr;

  assign thr  = halfMode ? {2'b00, reload[RLD_W-1:1]} : {1'b0, reload};
  assign sum  = accQ + ACC_W'(STEP);
  assign tick = (sum >= thr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      accQ <= '0;
    else if (clr)   accQ <= '0;
    else if (tick)  accQ <= sum - thr;
    else            accQ <= sum;
  end

endmodule

// File: rtl/fsl_datapath.sv
module fsl_datapath
  import fsl_pkg::*;
#(
  parameter int RLD_W        = 16,
  parameter int DBG_W        = 12,
  parameter int MIN_RELOAD   = 32,
  parameter int RESET_RELOAD = 256,
  parameter int SYNC_STAGES  = 2,
  parameter int DATA_W       = 8,
  parameter int STEP         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fslCtrl_t          ctrl,
  input  logic              dbgEn,
  input  logic              regWrEn,
  input  logic [RLD_W-1:0]  regWrData,
  input  logic              rxIn,
  input  logic [DATA_W-1:0] txData,
  output logic              rxBit,
  output logic              rxFall,
  output logic              rxTick,
  output logic              txTick,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  output logic              txOut,
  output logic [RLD_W-1:0]  reloadNow
);

  localparam int TX_W = DATA_W + 2;
  localparam logic [RLD_W-1:0] DBG_MASK = {{(RLD_W-DBG_W){1'b0}}, {DBG_W{1'b1}}};
  localparam logic [RLD_W-1:0] FLOOR    = RLD_W'(MIN_RELOAD);

  // reload staging
  logic [RLD_W-1:0] pendQ;
  logic [RLD_W-1:0] actQ;
  logic [RLD_W-1:0] masked;
  logic [RLD_W-1:0] effReload;

  always_comb begin
    masked    = dbgEn ? (pendQ & DBG_MASK) : pendQ;
    effReload = (masked < FLOOR) ? FLOOR : masked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= RLD_W'(RESET_RELOAD);
      actQ  <= RLD_W'(RESET_RELOAD);
    end else begin
      if (regWrEn)       pendQ <= regWrData;
      if (ctrl.reloadOk) actQ  <= effReload;
    end
  end

  assign reloadNow = actQ;

  // receive line synchronizer and edge detector
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      rxPrevQ <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], rxIn};
      rxPrevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rxBit  = syncQ[SYNC_STAGES-1];
  assign rxFall = rxPrevQ & ~rxBit;

  // phase accumulators, one per direction, sharing the active reload
  fsl_phase_acc #(.RLD_W(RLD_W), .STEP(STEP)) u_rxAcc (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (ctrl.rxClr),
    .halfMode (ctrl.rxHalf),
    .reload   (actQ),
    .tick     (rxTick)
  );

  fsl_phase_acc #(.RLD_W(RLD_W), .STEP(STEP)) u_txAcc (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (ctrl.txClr),
    .halfMode (1'b0),
    .reload   (actQ),
    .tick     (txTick)
  );

  // receive shifter and result registers
  logic [DATA_W-1:0] rxShiftQ;
  logic [DATA_W-1:0] rxDataQ;
  logic              rxErrQ;
  logic              rxValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      rxDataQ  <= '0;
      rxErrQ   <= 1'b0;
      rxValidQ <= 1'b0;
    end else begin
      rxValidQ <= ctrl.rxDone;
      if (ctrl.rxShift) rxShiftQ <= {rxBit, rxShiftQ[DATA_W-1:1]};
      if (ctrl.rxDone) begin
        rxDataQ <= rxShiftQ;
        rxErrQ  <= ~rxBit;
      end
    end
  end

  assign rxData     = rxDataQ;
  assign rxFrameErr = rxErrQ;
  assign rxValid    = rxValidQ;

  // transmit shifter: stop, data, start; bit 0 drives the line
  logic [TX_W-1:0] txShiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txShiftQ <= '1;
    else if (ctrl.txLoad)   txShiftQ <= {1'b1, txData, 1'b0};
    else if (ctrl.txShift)  txShiftQ <= {1'b1, txShiftQ[TX_W-1:1]};
  end

  assign txOut = txShiftQ[0];

endmodule

// File: rtl/fsl_control.sv
module fsl_control
  import fsl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxFall,
  input  logic     rxBit,
  input  logic     rxTick,
  input  logic     txTick,
  input  logic     txStart,
  output fslCtrl_t ctrl,
  output logic     txBusy
);

  localparam int TX_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(TX_W);

  rxState_e         rxStateQ;
  txState_e         txStateQ;
  logic [CNT_W-1:0] rxCntQ;
  logic [CNT_W-1:0] txCntQ;

  // receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStateQ <= RX_IDLE;
      rxCntQ   <= '0;
    end else begin
      unique case (rxStateQ)
        RX_IDLE:  if (rxFall) rxStateQ <= RX_START;
        RX_START: if (rxTick) begin
          rxCntQ   <= '0;
          rxStateQ <= rxBit ? RX_IDLE : RX_DATA;
        end
        RX_DATA:  if (rxTick) begin
          if (rxCntQ == CNT_W'(DATA_W - 1)) rxStateQ <= RX_STOP;
          else                              rxCntQ   <= rxCntQ + 1'b1;
        end
        RX_STOP:  if (rxTick) rxStateQ <= RX_IDLE;
        default:  rxStateQ <= RX_IDLE;
      endcase
    end
  end

  // transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStateQ <= TX_IDLE;
      txCntQ   <= '0;
    end else begin
      unique case (txStateQ)
        TX_IDLE: if (txStart) begin
          txStateQ <= TX_RUN;
          txCntQ   <= '0;
        end
        TX_RUN: if (txTick) begin
          if (txCntQ == CNT_W'(TX_W - 1)) txStateQ <= TX_IDLE;
          else                            txCntQ   <= txCntQ + 1'b1;
        end
        default: txStateQ <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.rxClr    = (rxStateQ == RX_IDLE);
    ctrl.rxHalf   = (rxStateQ == RX_START);
    ctrl.rxShift  = (rxStateQ == RX_DATA) && rxTick;
    ctrl.rxDone   = (rxStateQ == RX_STOP) && rxTick;
    ctrl.txClr    = (txStateQ == TX_IDLE);
    ctrl.txLoad   = (txStateQ == TX_IDLE) && txStart;
    ctrl.txShift  = (txStateQ == TX_RUN) && txTick;
    ctrl.reloadOk = (rxStateQ == RX_IDLE) && (txStateQ == TX_IDLE);
  end

  assign txBusy = (txStateQ == TX_RUN);

endmodule

// File: rtl/fsl_serial_link.sv
module fsl_serial_link
  import fsl_pkg::*;
#(
  parameter int RLD_W        = 16,
  parameter int DBG_W        = 12,
  parameter int MIN_RELOAD   = 32,
  parameter int RESET_RELOAD = 256,
  parameter int SYNC_STAGES  = 2,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEn,
  input  logic              regWrEn,
  input  logic [RLD_W-1:0]  regWrData,
  input  logic              rxIn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxFrameErr,
  input  logic              txStart,
  input  logic [DATA_W-1:0] txData,
  output logic              txBusy,
  output logic              txOut
);

  localparam int STEP = 8;

  fslCtrl_t         ctrl;
  logic             rxBit;
  logic             rxFall;
  logic             rxTick;
  logic             txTick;
  logic [RLD_W-1:0] reloadNow;

  fsl_control #(.DATA_W(DATA_W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .rxFall  (rxFall),
    .rxBit   (rxBit),
    .rxTick  (rxTick),
    .txTick  (txTick),
    .txStart (txStart),
    .ctrl    (ctrl),
    .txBusy  (txBusy)
  );

  fsl_datapath #(
    .RLD_W        (RLD_W),
    .DBG_W        (DBG_W),
    .MIN_RELOAD   (MIN_RELOAD),
    .RESET_RELOAD (RESET_RELOAD),
    .SYNC_STAGES  (SYNC_STAGES),
    .DATA_W       (DATA_W),
    .STEP         (STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .dbgEn      (dbgEn),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .rxIn       (rxIn),
    .txData     (txData),
    .rxBit      (rxBit),
    .rxFall     (rxFall),
    .rxTick     (rxTick),
    .txTick     (txTick),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxFrameErr (rxFrameErr),
    .txOut      (txOut),
    .reloadNow  (reloadNow)
  );

endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
  parameter int RLD_W      = 16,
  parameter int DBG_W      = 12,
  parameter int MIN_RELOAD = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             dbgEn,
  input logic             rxValid,
  input logic             txBusy,
  input logic             txOut,
  input logic [RLD_W-1:0] reloadNow
);

  localparam logic [RLD_W-1:0] FLOOR = RLD_W'(MIN_RELOAD);
  localparam logic [RLD_W:0]   DBG_LIMIT = (RLD_W+1)'(1) << DBG_W;

  // R3: received-byte strobe lasts one cycle
  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: line rests high outside a transmit frame
  a_r7_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

  // R9: active reload never below the floor
  a_r9_reload_floor: assert property (@(posedge clk) disable iff (!rstN)
    reloadNow >= FLOOR);

  // R8: a reload taken under debug enable fits the narrow width
  a_r8_debug_width: assert property (@(posedge clk) disable iff (!rstN)
    (reloadNow != $past(reloadNow)) && $past(dbgEn) |-> ({1'b0, reloadNow} < DBG_LIMIT));

  // R10: active reload frozen inside a transmit frame
  a_r10_reload_frozen: assert property (@(posedge clk) disable iff (!rstN)
    txBusy && $past(txBusy) |-> reloadNow == $past(reloadNow));

endmodule

bind fsl_serial_link fsl_checker #(
  .RLD_W      (RLD_W),
  .DBG_W      (DBG_W),
  .MIN_RELOAD (MIN_RELOAD)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dbgEn     (dbgEn),
  .rxValid   (rxValid),
  .txBusy    (txBusy),
  .txOut     (txOut),
  .reloadNow (reloadNow)
);

// File: tb/fsl_serial_link_tb.sv
module fsl_serial_link_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dbgEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        rxDrive = 1'b1;
  logic        loopBack = 1'b0;
  logic        rxIn;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxFrameErr;
  logic        txStart = 1'b0;
  logic [7:0]  txData = '0;
  logic        txBusy;
  logic        txOut;

  int checks = 0;
  int errors = 0;
  int rxSeen = 0;
  int busyCycles = 0;
  logic [7:0] lastData = '0;
  logic [7:0] prevData = '0;
  logic       lastErr = 1'b0;

  always #10 clk = ~clk;

  assign rxIn = loopBack ? txOut : rxDrive;

  fsl_serial_link u_dut (
    .clk(clk), .rstN(rstN), .dbgEn(dbgEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .rxIn(rxIn), .rxData(rxData), .rxValid(rxValid), .rxFrameErr(rxFrameErr),
    .txStart(txStart), .txData(txData), .txBusy(txBusy), .txOut(txOut)
  );

  // {reload, data, stop level, debug enable}
  localparam logic [25:0] VEC [0:5] = '{
    {16'd256,   8'hA5, 1'b1, 1'b0},
    {16'd300,   8'h3C, 1'b1, 1'b0},
    {16'd256,   8'h00, 1'b0, 1'b0},
    {16'h1100,  8'h5A, 1'b1, 1'b1},
    {16'd612,   8'hFF, 1'b1, 1'b0},
    {16'd256,   8'h81, 1'b0, 1'b0}
  };

  always @(negedge clk) begin
    if (rxValid) begin
      rxSeen   <= rxSeen + 1;
      prevData <= lastData;
      lastData <= rxData;
      lastErr  <= rxFrameErr;
    end
    if (txBusy) busyCycles <= busyCycles + 1;
  end

  function automatic int effReload(input logic [15:0] r, input logic dbg);
    int m;
    m = dbg ? int'(r & 16'h0FFF) : int'(r);
    return (m < 32) ? 32 : m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReload(input logic [15:0] v);
    @(negedge clk);
    regWrData = v;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // start bit and data bits on fractional edges, then a stop of given length
  task automatic sendRx(input int eff, input logic [7:0] d, input logic stopBit, input int stopCyc);
    for (int k = 0; k < 9; k++) begin
      rxDrive = (k == 0) ? 1'b0 : d[k-1];
      repeat (((k + 1) * eff) / 8 - (k * eff) / 8) @(negedge clk);
    end
    rxDrive = stopBit;
    repeat (stopCyc) @(negedge clk);
    rxDrive = 1'b1;
  endtask

  task automatic pulseTx(input logic [7:0] d);
    @(negedge clk);
    txData  = d;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
  endtask

  task automatic waitTxIdle();
    for (int i = 0; i < 20000 && txBusy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    int b0;
    int eff;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txOut == 1'b1, "R1 txOut", txOut, 1);
    check(txBusy == 1'b0, "R1 txBusy", txBusy, 0);
    check(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R8: vector table through the receiver
    foreach (VEC[i]) begin
      dbgEn = VEC[i][0];
      writeReload(VEC[i][25:10]);
      eff = effReload(VEC[i][25:10], VEC[i][0]);
      s0 = rxSeen;
      sendRx(eff, VEC[i][9:2], VEC[i][1], eff / 8);
      repeat (eff / 4) @(negedge clk);
      check(rxSeen == s0 + 1, "R3 one valid per frame", rxSeen - s0, 1);
      check(lastData == VEC[i][9:2], "R2 R8 data", lastData, VEC[i][9:2]);
      check(lastErr == ~VEC[i][1], "R4 frame error", lastErr, ~VEC[i][1]);
    end
    dbgEn = 1'b0;

    // R5: short low glitch is rejected
    writeReload(16'd256);
    s0 = rxSeen;
    rxDrive = 1'b0;
    repeat (3) @(negedge clk);
    rxDrive = 1'b1;
    repeat (400) @(negedge clk);
    check(rxSeen == s0, "R5 glitch ignored", rxSeen - s0, 0);

    // R6: shortened stop then immediate next frame
    s0 = rxSeen;
    sendRx(256, 8'h4E, 1'b1, 23);
    sendRx(256, 8'hB1, 1'b1, 32);
    repeat (100) @(negedge clk);
    check(rxSeen == s0 + 2, "R6 both frames", rxSeen - s0, 2);
    check(prevData == 8'h4E, "R6 first byte", prevData, 8'h4E);
    check(lastData == 8'hB1, "R6 second byte", lastData, 8'hB1);

    // R7 R10: transmit with loopback, reload written mid-frame
    loopBack = 1'b1;
    s0 = rxSeen;
    b0 = busyCycles;
    pulseTx(8'h96);
    repeat (50) @(negedge clk);
    check(txOut == 1'b0 || txOut == 1'b1, "R7 line driven", txOut, txOut);
    writeReload(16'd320);
    waitTxIdle();
    check(busyCycles - b0 == 320, "R10 old reload kept", busyCycles - b0, 320);
    check(txOut == 1'b1, "R7 idle high", txOut, 1);
    repeat (40) @(negedge clk);
    check(rxSeen == s0 + 1, "R7 loopback frame", rxSeen - s0, 1);
    check(lastData == 8'h96, "R7 loopback data", lastData, 8'h96);
    check(lastErr == 1'b0, "R7 stop high", lastErr, 0);

    // R10 R11: new reload applies; start during busy ignored
    s0 = rxSeen;
    b0 = busyCycles;
    pulseTx(8'h6D);
    repeat (100) @(negedge clk);
    pulseTx(8'h11);
    waitTxIdle();
    check(busyCycles - b0 == 400, "R10 R11 new reload length", busyCycles - b0, 400);
    repeat (60) @(negedge clk);
    check(rxSeen == s0 + 1, "R11 single frame", rxSeen - s0, 1);
    check(lastData == 8'h6D, "R11 data kept", lastData, 8'h6D);
    loopBack = 1'b0;

    // R9: clamp of small reload
    writeReload(16'd10);
    b0 = busyCycles;
    pulseTx(8'hC3);
    waitTxIdle();
    check(busyCycles - b0 == 40, "R9 clamp to 32", busyCycles - b0, 40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule